// File: doc/BRIEF.md
# Clock and Power-Mode Gating Controller

This block turns one master clock into three clock-enable streams: one for a CPU core, one for a peripheral domain (timers, counter array, watchdog, port sampling) and one for a USB domain. Every downstream flop keeps running on the master clock and advances only when its enable is high. Because each enable is decoded from registered state, no domain ever sees a glitch.

Software drives a small control register. Through it, software selects:
- idle, which stops the CPU stream only;
- power-down, which stops all three streams;
- a double-speed mode;
- a ratio bit that picks 6 or 12 master periods per peripheral cycle;
- the PLL enable.

A PLL lock input is brought into the clock domain through a synchronizer and shown as a read-only lock flag. The USB stream stays off until the flag is set. An interrupt wake request or a USB wake request clears both the idle and power-down bits.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset, the status word reads 0 and `cpu_ce`, `per_ce` and `usb_ce` are all low.
- R2: When idle and power-down are both clear, `cpu_ce` behaves as follows. With double-speed clear (status bit 2 = 0) it is high on every second master cycle, starting with the second cycle after reset. With double-speed set it is high on every cycle.
- R3: While the idle bit (status bit 0) is set, `cpu_ce` is low. `per_ce` and `usb_ce` keep their normal behaviour during idle.
- R4: While the power-down bit (status bit 1) is set, all three enables are low. The peripheral divider also holds its count, so it resumes from the same phase afterwards.
- R5: `per_ce` pulses once every 12 master cycles when double-speed is clear, whatever the ratio bit (status bit 3) holds. With double-speed set, the ratio bit picks the period: ratio 0 gives 6 cycles and ratio 1 gives 12.
- R6: The lock flag (status bit 5) is set on the third edge after `pll_lock_in` rises, provided the PLL enable bit (status bit 4) is set. It clears on the third edge after `pll_lock_in` falls. It also clears on the edge after the enable bit reads 0.
- R7: `usb_ce` is high exactly when the lock flag is set and power-down is clear.
- R8: A high `wake_irq` or `wake_usb` clears both the idle and power-down bits at the next edge. This holds even when a write in the same cycle sets those bits.
- R9: A write loads `reg_wdata` bits [4:0] as {pll_en, ratio, double-speed, power-down, idle}. `stat_rdata` returns the same five bits with the lock flag placed above them as bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 5 | Control write data {pll_en, ratio, dbl, pdown, idle} |
| pll_lock_in | input | 1 | Asynchronous PLL lock indication |
| wake_irq | input | 1 | Interrupt wake request |
| wake_usb | input | 1 | USB event wake request |
| cpu_ce | output | 1 | CPU domain clock enable |
| per_ce | output | 1 | Peripheral domain clock enable |
| usb_ce | output | 1 | USB domain clock enable |
| stat_rdata | output | 6 | Status word {lock, pll_en, ratio, dbl, pdown, idle} |

## Verification
The assertions check, on every cycle, the relations between the mode bits and the enables:
- idle or power-down forces the CPU enable off;
- power-down forces every enable off;
- a USB enable always implies the lock flag;
- double-speed run mode forces the CPU enable on;
- a wake request clears both sleep bits;
- a dropped PLL enable clears the lock flag.

The peripheral period under each ratio setting cannot be expressed as a short property. The same is true of the divider keeping its phase across power-down and of the synchronizer delay on lock. The bench's reference model covers these cycle by cycle over scenarios that switch modes in the middle of a period.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    localparam int CTRL_W = 5;
    localparam int STAT_W = CTRL_W + 1;

    // Field order is the software-visible bit order, LSB last.
    typedef struct packed {
        logic pll_en;
        logic ratio12;
        logic dbl;
        logic pdown;
        logic idle;
    } ctrl_t;

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = din;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/clkpm_perdiv.sv
module clkpm_perdiv #(
    parameter int SLOW = 12,
    parameter int FAST = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic fast_sel,
    output logic tick
);

    localparam int CW = $clog2(SLOW);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last  = fast_sel ? FAST_LAST : SLOW_LAST;
        cnt_d = cnt_q;
        if (!hold) begin
            // >= so a switch to the shorter period wraps at once
            if (cnt_q >= last) cnt_d = '0;
            else               cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = !hold && (cnt_q == last);

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
    import clkpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PER_SLOW    = 12,
    parameter int PER_FAST    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              pll_lock_in,
    input  logic              wake_irq,
    input  logic              wake_usb,
    output logic              cpu_ce,
    output logic              per_ce,
    output logic              usb_ce,
    output logic [STAT_W-1:0] stat_rdata
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  half;
        logic  lock;
    } state_t;

    state_t st_d, st_q;
    logic   lock_sync;
    logic   wake;

    clkpm_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pll_lock_in),
        .dout  (lock_sync)
    );

    clkpm_perdiv #(.SLOW(PER_SLOW), .FAST(PER_FAST)) u_perdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (st_q.ctrl.pdown),
        .fast_sel (st_q.ctrl.dbl && !st_q.ctrl.ratio12),
        .tick     (per_ce)
    );

    assign wake = wake_irq || wake_usb;

    always_comb begin
        st_d      = st_q;
        st_d.half = !st_q.half;
        if (reg_wr) st_d.ctrl = ctrl_t'(reg_wdata);
        if (wake) begin
            st_d.ctrl.idle  = 1'b0;
            st_d.ctrl.pdown = 1'b0;
        end
        st_d.lock = st_q.ctrl.pll_en && lock_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_ce     = !st_q.ctrl.idle && !st_q.ctrl.pdown &&
                        (st_q.ctrl.dbl || st_q.half);
    assign usb_ce     = st_q.lock && !st_q.ctrl.pdown;
    assign stat_rdata = {st_q.lock, st_q.ctrl};

endmodule

// File: rtl/clkpm_ctrl_chk.sv
module clkpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_irq,
    input logic       wake_usb,
    input logic       cpu_ce,
    input logic       per_ce,
    input logic       usb_ce,
    input logic [5:0] stat
);

    a_r3_idle_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
        stat[0] |-> !cpu_ce);

    a_r4_pdown_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        stat[1] |-> (!cpu_ce && !per_ce && !usb_ce));

    a_r7_usb_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        usb_ce |-> stat[5]);

    a_r8_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq || wake_usb) |=> (!stat[0] && !stat[1]));

    a_r6_lock_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[4] |=> !stat[5]);

    a_r2_fast_cpu_on: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[2] && !stat[0] && !stat[1]) |-> cpu_ce);

endmodule

bind clkpm_ctrl clkpm_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_irq (wake_irq),
    .wake_usb (wake_usb),
    .cpu_ce   (cpu_ce),
    .per_ce   (per_ce),
    .usb_ce   (usb_ce),
    .stat     (stat_rdata)
);

// File: tb/clkpm_ctrl_bench.sv
module clkpm_ctrl_bench;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_wdata = '0;
    logic       pll_lock_in = 1'b0;
    logic       wake_irq = 1'b0;
    logic       wake_usb = 1'b0;
    logic       cpu_ce, per_ce, usb_ce;
    logic [5:0] stat_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clkpm_ctrl u_clkpm_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .pll_lock_in (pll_lock_in),
        .wake_irq    (wake_irq),
        .wake_usb    (wake_usb),
        .cpu_ce      (cpu_ce),
        .per_ce      (per_ce),
        .usb_ce      (usb_ce),
        .stat_rdata  (stat_rdata)
    );

    // Behavioural reference model
    bit m_idle, m_pd, m_dbl, m_ratio, m_pllen, m_lock, m_half;
    int m_cnt;
    bit m_sq[SYNC];

    function automatic int per_len();
        return (m_dbl && !m_ratio) ? 6 : 12;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_idle, m_pd, m_dbl, m_ratio, m_pllen, m_lock, m_half} = '0;
            m_cnt = 0;
            foreach (m_sq[i]) m_sq[i] = 1'b0;
        end else begin
            bit new_lock;
            int len;
            new_lock = m_pllen && m_sq[SYNC-1];
            len = per_len();
            if (!m_pd) m_cnt = (m_cnt >= len - 1) ? 0 : m_cnt + 1;
            for (int i = SYNC - 1; i > 0; i--) m_sq[i] = m_sq[i-1];
            m_sq[0] = pll_lock_in;
            m_half = !m_half;
            m_lock = new_lock;
            if (reg_wr) {m_pllen, m_ratio, m_dbl, m_pd, m_idle} = reg_wdata;
            if (wake_irq || wake_usb) begin
                m_idle = 1'b0;
                m_pd = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2/R3 cpu_ce", cpu_ce, !m_idle && !m_pd && (m_dbl || m_half));
        chk("R5/R4 per_ce", per_ce, !m_pd && (m_cnt == per_len() - 1));
        chk("R7 usb_ce", usb_ce, m_lock && !m_pd);
        chk("R9/R6 stat_rdata", stat_rdata,
            {m_lock, m_pllen, m_ratio, m_dbl, m_pd, m_idle});
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [4:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        step();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state before any active edge
        chk("R1 stat", stat_rdata, 0);
        chk("R1 cpu_ce", cpu_ce, 0);
        chk("R1 per_ce", per_ce, 0);
        chk("R1 usb_ce", usb_ce, 0);

        run(30);                       // standard mode: R2, R5
        wr(5'b00100); run(20);         // double speed, ratio 6: R5, R2
        wr(5'b01100); run(30);         // double speed, ratio 12: R5
        wr(5'b01000); run(30);         // ratio set, standard mode: R5 no effect
        wr(5'b00100); run(3);
        wr(5'b00101); run(15);         // idle: R3
        chk("R3 idle bit", stat_rdata[0], 1);
        wake_irq = 1'b1; step(); wake_irq = 1'b0;
        chk("R8 idle cleared by irq", stat_rdata[0], 0);
        run(10);
        wr(5'b00010); run(25);         // power-down: R4
        wake_usb = 1'b1; step(); wake_usb = 1'b0;
        chk("R8 pdown cleared by usb", stat_rdata[1], 0);
        run(15);
        // PLL lock: R6, R7
        wr(5'b10000);
        pll_lock_in = 1'b1;
        step(); step();
        chk("R6 lock not yet", stat_rdata[5], 0);
        step();
        chk("R6 lock set", stat_rdata[5], 1);
        chk("R7 usb running", usb_ce, 1);
        run(5);
        wr(5'b10010); run(6);          // power-down with lock: R7, R4
        chk("R4 usb stopped", usb_ce, 0);
        wake_irq = 1'b1; step(); wake_irq = 1'b0; run(4);
        pll_lock_in = 1'b0; run(5);    // lock loss: R6
        chk("R6 lock lost", stat_rdata[5], 0);
        pll_lock_in = 1'b1; run(5);
        wr(5'b00000); run(3);          // PLL disable clears lock: R6
        chk("R6 lock cleared by disable", stat_rdata[5], 0);
        // R8: wake beats a simultaneous write
        reg_wr = 1'b1; reg_wdata = 5'b00011; wake_usb = 1'b1;
        step();
        reg_wr = 1'b0; wake_usb = 1'b0;
        chk("R8 wake wins", stat_rdata[1:0], 0);
        run(10);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule